// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from a parameterized set of sources and decides which one, if any, the CPU should take next. Each source owns a sticky pending flag, an enable bit and a 3-bit priority field, all held in memory-mapped registers behind a small register bus. Every cycle an arbiter selects the enabled, pending source with the highest non-zero priority, breaking ties toward the lower source index. The winner's vector number and level are latched and compared with the current CPU level, and a request is raised toward the CPU only when the winner is strictly above that level.

The CPU level is four bits. Software owns the low three bits. The top bit follows a trap input, so software cannot lower the level below a trap. When the CPU takes a request with an acknowledge pulse, the block raises the software level to the accepted level and moves its service state machine from `S_IDLE` to `S_SERV` (transition "accept"). A done pulse moves it back from `S_SERV` to `S_IDLE` (transition "finish"). An acknowledge in `S_SERV` keeps the machine in `S_SERV` (transition "nest"). While the machine is in `S_SERV` and the nesting-off control bit is set, no request is raised.

Top module: `prio_irq_ctrl`

Register map (4-bit word address, 16-bit data):

| Address | Name | Contents |
|---|---|---|
| 0 | control | bit 0 is nesting-off |
| 1 | pending | bit n is the flag of source n; a write clears the bits written as 1 |
| 2 | enable | bit n is the enable of source n |
| 3 | level | bits [2:0] are writable; bit 3 is read-only and follows `cpu_trap_i` |
| 4 | status | bits [6:0] hold the latched vector, bits [11:8] the latched level |
| 8 + n/4 | priority | bits [4*(n%4)+2 : 4*(n%4)] hold the priority of source n |

## Requirements
- R1: A high `src_req_i[n]` sets pending bit n (address 1). The bit stays set until a bus write to address 1 carries a 1 in bit n. If a source sets a bit in the same cycle that a write clears it, the bit stays set.
- R2: A source whose enable bit n (address 2) is 0 never wins arbitration, never appears on the vector output and never raises `irq_req_o`.
- R3: The priority of source n is held in the register at address 8+n/4, bits [4*(n%4)+2 : 4*(n%4)]. A priority of 0 means the source never wins.
- R4: The vector of source n is n+8 and its level is {0, priority}. Both appear on `irq_vec_o` and `irq_lvl_o` and in the status register (vector in bits [6:0], level in bits [11:8]). When no source qualifies, both are 0.
- R5: The highest priority among pending, enabled sources wins. Among equal priorities, the lowest index wins.
- R6: `irq_req_o` is high only when the latched level is strictly greater than the CPU level {`cpu_trap_i`, software bits}.
- R7: A write to address 3 changes only bits [2:0]. Bit 3 of the read value and of `cpu_lvl_o` equals `cpu_trap_i`.
- R8: An `irq_ack_i` pulse while `irq_req_o` is high sets the software level to the accepted level and drops `irq_req_o` on the next cycle. The pending flag stays set.
- R9: In `S_SERV` with nesting-off set, `irq_req_o` stays low. A done pulse (`S_SERV` to `S_IDLE`) allows requests again. With nesting-off clear, a higher-level request is raised in `S_SERV`.
- R10: A source pulse sampled at clock edge k updates the pending flag at edge k. The vector, level and request outputs reflect it after edge k+1.
- R11: Synchronous active-high reset clears all flags, enables, priorities, control and level bits, as well as the outputs and the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| src_req_i | input | 8 | Request pulses, one per source |
| cpu_trap_i | input | 1 | Trap level active; forms bit 3 of the CPU level |
| irq_ack_i | input | 1 | CPU accepts the presented request |
| irq_done_i | input | 1 | CPU finished servicing the current interrupt |
| irq_req_o | output | 1 | Interrupt request to the CPU |
| irq_vec_o | output | 7 | Latched vector number of the winner |
| irq_lvl_o | output | 4 | Latched level of the winner |
| cpu_lvl_o | output | 4 | Current CPU level |

## Verification
Assertions check four properties on every cycle. A cleared flag always goes with a write to the pending register. The arbitration winner is always pending and enabled. A raised request always carries an in-range vector and a non-zero, non-trap level, and it drops after an acceptance. Nesting-off blocks requests during service, and an acceptance loads the level. The bench scenarios are needed for the behaviours that depend on values: which source wins a tie, the exact field positions of the priorities, the one-cycle latency, the strict comparison at an equal level, the trap bit that software cannot write, and the outcome when a set and a clear hit the same bit in the same cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
    localparam logic [ADDR_W-1:0] A_FLAG = 4'd1;
    localparam logic [ADDR_W-1:0] A_EN   = 4'd2;
    localparam logic [ADDR_W-1:0] A_LVL  = 4'd3;
    localparam logic [ADDR_W-1:0] A_STAT = 4'd4;
    localparam int                A_PRIO = 8;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_SERV = 1'b1
    } svc_state_e;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int N  = 8,
    parameter int PW = 3,
    parameter int LW = 4,
    parameter int VW = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N-1:0]      src_req_i,
    input  logic              trap_i,
    input  logic              ack_take_i,
    input  logic [PW-1:0]     ack_lvl_i,
    input  logic [VW-1:0]     stat_vec_i,
    input  logic [LW-1:0]     stat_lvl_i,
    output logic [N-1:0]      flags_o,
    output logic [N-1:0]      en_o,
    output logic [N*PW-1:0]   prio_o,
    output logic              nest_off_o,
    output logic [LW-1:0]     cur_lvl_o
);
    localparam int SLOT = 4;

    logic [N-1:0]  flags_q, en_q;
    logic [PW-1:0] lvl_sw_q;
    logic          nest_q;
    logic [PW-1:0] prio_q [N];
    logic          w_flag, w_en, w_ctrl, w_lvl;

    assign w_flag = bus_we && (bus_addr == A_FLAG);
    assign w_en   = bus_we && (bus_addr == A_EN);
    assign w_ctrl = bus_we && (bus_addr == A_CTRL);
    assign w_lvl  = bus_we && (bus_addr == A_LVL);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q  <= '0;
            en_q     <= '0;
            nest_q   <= 1'b0;
            lvl_sw_q <= '0;
        end else begin
            // a new request wins over a simultaneous clear
            flags_q <= (flags_q & ~(w_flag ? bus_wdata[N-1:0] : '0)) | src_req_i;
            if (w_en)   en_q   <= bus_wdata[N-1:0];
            if (w_ctrl) nest_q <= bus_wdata[0];
            if (ack_take_i)  lvl_sw_q <= ack_lvl_i;
            else if (w_lvl)  lvl_sw_q <= bus_wdata[PW-1:0];
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_prio
        localparam logic [ADDR_W-1:0] RA = ADDR_W'(A_PRIO + i / SLOT);
        localparam int                BP = SLOT * (i % SLOT);
        always_ff @(posedge clk) begin
            if (rst)                               prio_q[i] <= '0;
            else if (bus_we && (bus_addr == RA))   prio_q[i] <= bus_wdata[BP +: PW];
        end
        assign prio_o[i*PW +: PW] = prio_q[i];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL) bus_rdata[0]        = nest_q;
        if (bus_addr == A_FLAG) bus_rdata[N-1:0]    = flags_q;
        if (bus_addr == A_EN)   bus_rdata[N-1:0]    = en_q;
        if (bus_addr == A_LVL)  bus_rdata[LW-1:0]   = {trap_i, lvl_sw_q};
        if (bus_addr == A_STAT) begin
            bus_rdata[VW-1:0]  = stat_vec_i;
            bus_rdata[8 +: LW] = stat_lvl_i;
        end
        for (int i = 0; i < N; i++) begin
            if (bus_addr == ADDR_W'(A_PRIO + i / SLOT))
                bus_rdata[SLOT*(i%SLOT) +: PW] = prio_q[i];
        end
    end

    assign flags_o    = flags_q;
    assign en_o       = en_q;
    assign nest_off_o = nest_q;
    assign cur_lvl_o  = {trap_i, lvl_sw_q};

    a_r1_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        !w_flag |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    a_r8_ack_loads_level: assert property (@(posedge clk) disable iff (rst)
        ack_take_i |=> (lvl_sw_q == $past(ack_lvl_i)));
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb #(
    parameter int N  = 8,
    parameter int PW = 3,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]    flags_i,
    input  logic [N-1:0]    en_i,
    input  logic [N*PW-1:0] prio_i,
    output logic            win_valid_o,
    output logic [IW-1:0]   win_idx_o,
    output logic [PW-1:0]   win_lvl_o
);
    logic [PW-1:0] eff [N];

    for (genvar i = 0; i < N; i++) begin : g_eff
        assign eff[i] = (flags_i[i] && en_i[i]) ? prio_i[i*PW +: PW] : '0;
    end

    always_comb begin
        win_lvl_o = '0;
        win_idx_o = '0;
        // strict compare: a lower index keeps the win on a tie
        for (int i = 0; i < N; i++) begin
            if (eff[i] > win_lvl_o) begin
                win_lvl_o = eff[i];
                win_idx_o = IW'(i);
            end
        end
        win_valid_o = (win_lvl_o != '0);
    end
endmodule

// File: rtl/irqc_core.sv
module irqc_core
    import irqc_pkg::*;
#(
    parameter int N       = 8,
    parameter int PW      = 3,
    parameter int LW      = 4,
    parameter int VW      = 7,
    parameter int VEC_OFS = 8,
    parameter int IW      = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          win_valid_i,
    input  logic [IW-1:0] win_idx_i,
    input  logic [PW-1:0] win_lvl_i,
    input  logic [LW-1:0] cur_lvl_i,
    input  logic          nest_off_i,
    input  logic          ack_i,
    input  logic          done_i,
    output logic          req_o,
    output logic [VW-1:0] vec_o,
    output logic [LW-1:0] lvl_o,
    output logic          ack_take_o
);
    svc_state_e    state_q, state_d;
    logic          req_d;
    logic [VW-1:0] vec_d;
    logic [LW-1:0] lvl_d;

    assign ack_take_o = ack_i && req_o;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (ack_take_o) state_d = S_SERV;   // accept
            S_SERV: if (done_i)     state_d = S_IDLE;   // finish; ack here = nest
            default:                state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        vec_d = win_valid_i ? (VW'(win_idx_i) + VW'(VEC_OFS)) : '0;
        lvl_d = win_valid_i ? LW'(win_lvl_i) : '0;
        req_d = win_valid_i && (LW'(win_lvl_i) > cur_lvl_i)
                && !((state_q == S_SERV) && nest_off_i) && !ack_take_o;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_o <= 1'b0;
            vec_o <= '0;
            lvl_o <= '0;
        end else begin
            req_o <= req_d;
            vec_o <= vec_d;
            lvl_o <= lvl_d;
        end
    end

    a_r9_nest_blocks: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_SERV && nest_off_i) |=> !req_o);

    a_r4_vec_range: assert property (@(posedge clk) disable iff (rst)
        req_o |-> (int'(vec_o) >= VEC_OFS && int'(vec_o) < VEC_OFS + N));

    a_r6_req_level: assert property (@(posedge clk) disable iff (rst)
        req_o |-> (lvl_o != '0 && !lvl_o[LW-1]));

    a_r8_ack_drops_req: assert property (@(posedge clk) disable iff (rst)
        ack_take_o |=> !req_o);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int N       = 8,
    parameter int PW      = 3,
    parameter int LW      = 4,
    parameter int VW      = 7,
    parameter int VEC_OFS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N-1:0]      src_req_i,
    input  logic              cpu_trap_i,
    input  logic              irq_ack_i,
    input  logic              irq_done_i,
    output logic              irq_req_o,
    output logic [VW-1:0]     irq_vec_o,
    output logic [LW-1:0]     irq_lvl_o,
    output logic [LW-1:0]     cpu_lvl_o
);
    localparam int IW = $clog2(N);

    logic [N-1:0]    flags, en;
    logic [N*PW-1:0] prio;
    logic            nest_off, ack_take, win_valid;
    logic [IW-1:0]   win_idx;
    logic [PW-1:0]   win_lvl;
    logic [LW-1:0]   cur_lvl;

    irqc_regs #(.N(N), .PW(PW), .LW(LW), .VW(VW)) i_regs (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_req_i(src_req_i), .trap_i(cpu_trap_i),
        .ack_take_i(ack_take), .ack_lvl_i(irq_lvl_o[PW-1:0]),
        .stat_vec_i(irq_vec_o), .stat_lvl_i(irq_lvl_o),
        .flags_o(flags), .en_o(en), .prio_o(prio),
        .nest_off_o(nest_off), .cur_lvl_o(cur_lvl)
    );

    irqc_arb #(.N(N), .PW(PW), .IW(IW)) i_arb (
        .flags_i(flags), .en_i(en), .prio_i(prio),
        .win_valid_o(win_valid), .win_idx_o(win_idx), .win_lvl_o(win_lvl)
    );

    irqc_core #(.N(N), .PW(PW), .LW(LW), .VW(VW), .VEC_OFS(VEC_OFS), .IW(IW)) i_core (
        .clk(clk), .rst(rst),
        .win_valid_i(win_valid), .win_idx_i(win_idx), .win_lvl_i(win_lvl),
        .cur_lvl_i(cur_lvl), .nest_off_i(nest_off),
        .ack_i(irq_ack_i), .done_i(irq_done_i),
        .req_o(irq_req_o), .vec_o(irq_vec_o), .lvl_o(irq_lvl_o),
        .ack_take_o(ack_take)
    );

    assign cpu_lvl_o = cur_lvl;

    a_r2_winner_enabled: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> (flags[win_idx] && en[win_idx]));
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  bus_addr;
    logic        bus_we;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic [7:0]  src_req_i;
    logic        cpu_trap_i, irq_ack_i, irq_done_i;
    logic        irq_req_o;
    logic [6:0]  irq_vec_o;
    logic [3:0]  irq_lvl_o, cpu_lvl_o;

    int checks = 0;
    int errors = 0;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_req_i(src_req_i),
        .cpu_trap_i(cpu_trap_i), .irq_ack_i(irq_ack_i), .irq_done_i(irq_done_i),
        .irq_req_o(irq_req_o), .irq_vec_o(irq_vec_o), .irq_lvl_o(irq_lvl_o),
        .cpu_lvl_o(cpu_lvl_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [7:0]  fl;
        logic [7:0]  en;
        logic [15:0] p0;
        logic [15:0] p1;
        logic [2:0]  cl;
        logic [6:0]  vec;
        logic [3:0]  lv;
        logic        rq;
    } vec_t;

    localparam vec_t TBL [7] = '{
        '{8'h01, 8'h01, 16'h0003, 16'h0000, 3'd0, 7'd8,  4'd3, 1'b1},  // R4 R3 single source
        '{8'h0A, 8'hFF, 16'h5020, 16'h0000, 3'd0, 7'd11, 4'd5, 1'b1},  // R5 higher wins
        '{8'h30, 8'hFF, 16'h0000, 16'h0044, 3'd0, 7'd12, 4'd4, 1'b1},  // R5 tie, low index
        '{8'h81, 8'h80, 16'h0007, 16'h2000, 3'd0, 7'd15, 4'd2, 1'b1},  // R2 enable masks
        '{8'h04, 8'hFF, 16'h0300, 16'h0000, 3'd3, 7'd10, 4'd3, 1'b0},  // R6 equal level
        '{8'h40, 8'hFF, 16'h0000, 16'h0000, 3'd0, 7'd0,  4'd0, 1'b0},  // R3 prio 0
        '{8'h60, 8'hFF, 16'h0000, 16'h0660, 3'd2, 7'd13, 4'd6, 1'b1}   // R5 R6 tie above level
    };

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        tick();
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output int d);
        bus_addr = a;
        #1;
        d = int'(bus_rdata);
    endtask

    task automatic pulse(logic [7:0] m);
        src_req_i = m;
        tick();
        src_req_i = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int d;
        rst = 1'b1; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
        src_req_i = '0; cpu_trap_i = 1'b0; irq_ack_i = 1'b0; irq_done_i = 1'b0;
        @(negedge clk); tick(); tick();
        rst = 1'b0;

        // R11 reset state
        check("R11 req", int'(irq_req_o), 0);
        check("R11 vec", int'(irq_vec_o), 0);
        check("R11 cpu level", int'(cpu_lvl_o), 0);
        rd(4'd1, d); check("R11 flags", d, 0);
        rd(4'd2, d); check("R11 enables", d, 0);
        rd(4'd8, d); check("R11 prio", d, 0);

        for (int k = 0; k < 7; k++) begin
            wr(4'd1, 16'hFFFF);
            wr(4'd2, {8'h00, TBL[k].en});
            wr(4'd8, TBL[k].p0);
            wr(4'd9, TBL[k].p1);
            wr(4'd3, {13'd0, TBL[k].cl});
            pulse(TBL[k].fl);
            tick();
            check("R4 R5 table vec", int'(irq_vec_o), int'(TBL[k].vec));
            check("R4 R5 table level", int'(irq_lvl_o), int'(TBL[k].lv));
            check("R6 R2 table req", int'(irq_req_o), int'(TBL[k].rq));
            rd(4'd4, d);
            check("R4 table status", d, (int'(TBL[k].lv) << 8) | int'(TBL[k].vec));
        end

        // R1 sticky flags and write-one-to-clear
        wr(4'd1, 16'hFFFF);
        wr(4'd2, 16'h00FF);
        wr(4'd8, 16'h0011);
        wr(4'd3, 16'h0000);
        pulse(8'h03);
        tick(); tick();
        rd(4'd1, d); check("R1 flags held", d, 3);
        wr(4'd1, 16'h0001);
        rd(4'd1, d); check("R1 clear one bit", d, 2);
        src_req_i = 8'h01; bus_addr = 4'd1; bus_wdata = 16'h0001; bus_we = 1'b1;
        tick();
        src_req_i = '0; bus_we = 1'b0;
        rd(4'd1, d); check("R1 set beats clear", d, 3);

        // R10 latency
        wr(4'd1, 16'hFFFF);
        wr(4'd8, 16'h0600);
        tick();
        src_req_i = 8'h04;
        tick();
        src_req_i = '0;
        check("R10 not yet", int'(irq_req_o), 0);
        rd(4'd1, d); check("R10 flag at edge k", d, 4);
        tick();
        check("R10 req after k+1", int'(irq_req_o), 1);
        check("R10 vec after k+1", int'(irq_vec_o), 10);

        // R7 level register and trap bit
        wr(4'd3, 16'h000F);
        rd(4'd3, d); check("R7 bit3 not writable", d, 7);
        tick();
        check("R6 blocked by level 7", int'(irq_req_o), 0);
        wr(4'd3, 16'h0000);
        cpu_trap_i = 1'b1;
        tick();
        rd(4'd3, d); check("R7 trap bit read", d, 8);
        tick();
        check("R6 blocked by trap", int'(irq_req_o), 0);
        cpu_trap_i = 1'b0;
        tick(); tick();
        check("R6 req after trap", int'(irq_req_o), 1);

        // R8 acceptance, R9 nesting-off
        wr(4'd0, 16'h0001);
        irq_ack_i = 1'b1;
        tick();
        irq_ack_i = 1'b0;
        check("R8 level raised", int'(cpu_lvl_o), 6);
        check("R8 req dropped", int'(irq_req_o), 0);
        rd(4'd1, d); check("R8 flag kept", d, 4);
        wr(4'd8, 16'h0670);
        pulse(8'h02);
        tick(); tick();
        check("R9 blocked in service", int'(irq_req_o), 0);
        check("R9 winner latched", int'(irq_vec_o), 9);
        irq_done_i = 1'b1;
        tick();
        irq_done_i = 1'b0;
        tick();
        check("R9 req after done", int'(irq_req_o), 1);
        irq_ack_i = 1'b1;
        tick();
        irq_ack_i = 1'b0;
        check("R8 level 7", int'(cpu_lvl_o), 7);
        wr(4'd0, 16'h0000);
        wr(4'd3, 16'h0003);
        tick();
        check("R9 nesting allowed", int'(irq_req_o), 1);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule